// File: doc/BRIEF.md
# Sensorless Spindle Start-Up Mode Controller

This block is the mode controller of a three-phase sensorless brushless spindle drive. It owns a six-state commutation phase counter (values 1 to 6) and decides, from the output-enable and run/brake levels, when the power stage is driven, tristated, coasting or braking. An automatic start aligns the rotor in two steps timed by a slow alignment reference clock, then hands commutation to validated back-EMF zero-crossing events. An alternative external stepping mode lets a host advance the phase with a strobe.

When output-enable drops while the motor spins, the drivers float and the phase is held. When output-enable returns, the controller waits for a zero crossing to lock back on before it drives again. Dropping run/brake gives a coast interval with every driver off, and then a brake with all low-side switches on. A watchdog on the alignment reference stops any start while that clock is absent. Analog drive, current control and zero-crossing detection live outside the block.

Top module: `spindle_mode_ctrl`

## Requirements
- R1: After reset, and one cycle after run_brk is low in any driving state, phase is 1 and drv_en is 0. Reset also leaves brake at 0.
- R2: With run_brk and out_en high and the reference present, the controller starts in the first alignment step with phase 2 and drv_en 1. It holds there for ALIGN1_CYC (default 64) rising edges of align_ref.
- R3: The ALIGN1_CYC-th reference edge adds two to the phase (phase 4). The controller holds there for ALIGN2_CYC (default 192) reference edges.
- R4: The ALIGN2_CYC-th reference edge adds two again (phase 6) and enters run. In run each zc_evt pulse adds one to the phase on the next clock.
- R5: During both alignment steps, seq_step has no effect on the phase.
- R6: seq_step high while idle (phase 1, drivers off) with out_en low selects external stepping until the next reset. A start in that mode keeps phase 1 with drv_en 1. Each rising edge of seq_step then adds one to the phase, and zc_evt is ignored while seq_step is high.
- R7: In external stepping mode with seq_step low, each zc_evt adds one to the phase.
- R8: out_en low in a driving state clears drv_en on the next clock and holds the phase; zc_evt then leaves the phase unchanged.
- R9: When out_en returns, drv_en stays 0 until a zc_evt. That event adds one to the phase and turns the drivers back on.
- R10: After run_brk falls, the controller coasts with drv_en 0 and brake 0 for BRAKE_DLY clocks, then sets brake to 1 with drv_en 0.
- R11: The reference counts as missing from reset until its first edge, and again after WD_LIMIT (default 65536) clocks with no edge. While it is missing, no start or resync turns the drivers on.
- R12: The phase wraps from 6 to 1 on a single step, and from 5 to 1 on a double step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| out_en | input | 1 | High lets the power stage drive; low tristates it |
| run_brk | input | 1 | High requests spin, low requests coast then brake |
| seq_step | input | 1 | External phase step strobe, also selects stepping mode |
| align_ref | input | 1 | Slow alignment reference clock, asynchronous |
| zc_evt | input | 1 | One-clock pulse per validated back-EMF zero crossing |
| phase | output | 3 | Commutation phase, 1 to 6 |
| drv_en | output | 1 | Power drivers enabled |
| brake | output | 1 | All low-side switches on, high-side off |

## Verification
The bench counts reference edges exactly at both alignment boundaries. A controller that is off by one edge shows the wrong phase at the 63rd/64th or 191st/192th reference pulse. It checks phase wrap in run and stepping modes, where a wrong modulo gives 7 or 0. In stepping mode it drives a zero crossing while the strobe is held, and a strobe rise together with a crossing, where leaky masking gives double steps. It checks that a resync keeps the drivers off until a crossing arrives, that brake is timed against BRAKE_DLY, and that a start is refused with the reference stopped.

// File: rtl/spm_pkg.sv
package spm_pkg;

  typedef logic [2:0] phase_t;

  localparam phase_t PH_FIRST = 3'd1;
  localparam phase_t PH_LAST  = 3'd6;

  typedef enum logic [3:0] {
    M_IDLE,
    M_AL1,
    M_AL2,
    M_RUN,
    M_EXT,
    M_TRI,
    M_RSY,
    M_COAST,
    M_BRAKE
  } mode_t;

  // Advance a 1..6 phase by n steps (n = 0..2), wrapping past 6.
  function automatic phase_t phase_adv(input phase_t p, input logic [1:0] n);
    logic [3:0] s;
    s = {1'b0, p} + {2'b00, n};
    if (s > 4'd6) s = s - 4'd6;
    return s[2:0];
  endfunction

endpackage

// File: rtl/spm_ref_watch.sv
module spm_ref_watch #(
  parameter int WD_LIMIT = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic align_ref,
  output logic ref_tick,
  output logic ref_ok
);
  localparam int CW = $clog2(WD_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(WD_LIMIT);

  logic [2:0]    sh;
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], align_ref};
  end

  assign ref_tick = sh[1] & ~sh[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idle_cnt <= LIM;
    else if (ref_tick)       idle_cnt <= '0;
    else if (idle_cnt != LIM) idle_cnt <= idle_cnt + 1'b1;
  end

  assign ref_ok = (idle_cnt != LIM);

  // R11: a reference edge always revives the watchdog
  a_r11_edge_revives: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> ref_ok);
  // R11: once missing, only an edge clears the condition
  a_r11_stays_missing: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_ok && !ref_tick) |=> !ref_ok);

endmodule

// File: rtl/spm_strobe_edge.sv
module spm_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;

endmodule

// File: rtl/spm_phase_reg.sv
module spm_phase_reg
  import spm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   step1,
  input  logic   step2,
  output phase_t phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase <= PH_FIRST;
    else if (clr)   phase <= PH_FIRST;
    else if (step2) phase <= phase_adv(phase, 2'd2);
    else if (step1) phase <= phase_adv(phase, 2'd1);
  end

  // R12: the phase never leaves 1..6
  a_r12_range: assert property (@(posedge clk) disable iff (!rst_n)
    (phase >= PH_FIRST) && (phase <= PH_LAST));
  // R12: every change is a wrapped single or double step, or a return to 1
  a_r12_legal_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |->
      ((phase == phase_adv($past(phase), 2'd1)) ||
       (phase == phase_adv($past(phase), 2'd2)) ||
       (phase == PH_FIRST)));

endmodule

// File: rtl/spm_mode_fsm.sv
module spm_mode_fsm
  import spm_pkg::*;
#(
  parameter int ALIGN1_CYC = 64,
  parameter int ALIGN2_CYC = 192,
  parameter int BRAKE_DLY  = 1000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_brk,
  input  logic  out_en,
  input  logic  seq_step,
  input  logic  seq_rise,
  input  logic  zc_evt,
  input  logic  ref_tick,
  input  logic  ref_ok,
  output logic  clr,
  output logic  step1,
  output logic  step2,
  output logic  drv_en,
  output logic  brake
);
  localparam int AMAX = (ALIGN2_CYC > ALIGN1_CYC) ? ALIGN2_CYC : ALIGN1_CYC;
  localparam int AW   = $clog2(AMAX + 1);
  localparam int BW   = $clog2(BRAKE_DLY + 1);
  localparam logic [AW-1:0] A1_LAST = AW'(ALIGN1_CYC - 1);
  localparam logic [AW-1:0] A2_LAST = AW'(ALIGN2_CYC - 1);
  localparam logic [BW-1:0] B_LAST  = BW'(BRAKE_DLY - 1);

  mode_t         mode, nxt;
  logic          ext_mode;
  logic [AW-1:0] al_cnt;
  logic [BW-1:0] co_cnt;
  logic          start_ok;

  assign start_ok = out_en & ref_ok;

  always_comb begin
    nxt   = mode;
    clr   = 1'b0;
    step1 = 1'b0;
    step2 = 1'b0;
    if (!run_brk) begin
      unique case (mode)
        M_IDLE:  nxt = M_IDLE;
        M_BRAKE: nxt = M_BRAKE;
        M_COAST: if (co_cnt == B_LAST) nxt = M_BRAKE;
        default: begin nxt = M_COAST; clr = 1'b1; end
      endcase
    end else begin
      unique case (mode)
        M_IDLE, M_COAST, M_BRAKE: begin
          if (start_ok) begin
            if (ext_mode) nxt = M_EXT;
            else begin nxt = M_AL1; step1 = 1'b1; end
          end else if (mode == M_COAST && co_cnt == B_LAST) begin
            nxt = M_BRAKE;
          end
        end
        M_AL1: begin
          if (!out_en)      nxt = M_TRI;
          else if (!ref_ok) begin nxt = M_IDLE; clr = 1'b1; end
          else if (ref_tick && al_cnt == A1_LAST) begin nxt = M_AL2; step2 = 1'b1; end
        end
        M_AL2: begin
          if (!out_en)      nxt = M_TRI;
          else if (!ref_ok) begin nxt = M_IDLE; clr = 1'b1; end
          else if (ref_tick && al_cnt == A2_LAST) begin nxt = M_RUN; step2 = 1'b1; end
        end
        M_RUN: begin
          if (!out_en)     nxt = M_TRI;
          else if (zc_evt) step1 = 1'b1;
        end
        M_EXT: begin
          if (!out_en) nxt = M_TRI;
          else if (seq_rise || (zc_evt && !seq_step)) step1 = 1'b1;
        end
        M_TRI: if (out_en) nxt = M_RSY;
        M_RSY: begin
          if (!out_en) nxt = M_TRI;
          else if (zc_evt && ref_ok) begin
            step1 = 1'b1;
            nxt   = ext_mode ? M_EXT : M_RUN;
          end
        end
        default: begin nxt = M_IDLE; clr = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= M_IDLE;
    else        mode <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    ext_mode <= 1'b0;
    else if (mode == M_IDLE && seq_step && !out_en) ext_mode <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          al_cnt <= '0;
    else if (nxt != mode)                                al_cnt <= '0;
    else if (ref_tick && (mode == M_AL1 || mode == M_AL2)) al_cnt <= al_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               co_cnt <= '0;
    else if (nxt != mode)     co_cnt <= '0;
    else if (mode == M_COAST) co_cnt <= co_cnt + 1'b1;
  end

  assign drv_en = (mode == M_AL1) || (mode == M_AL2) || (mode == M_RUN) || (mode == M_EXT);
  assign brake  = (mode == M_BRAKE);

  // R6: a held strobe masks zero crossings in stepping mode
  a_r6_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_EXT && run_brk && out_en && seq_step && !seq_rise) |-> !step1);
  // R5: the strobe never steps the phase during alignment
  a_r5_align_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_AL1 || mode == M_AL2) && !ref_tick) |-> !(step1 || step2));
  // R10: brake is only reached through the coast interval
  a_r10_via_coast: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brake) |-> $past(mode == M_COAST));

endmodule

// File: rtl/spindle_mode_ctrl.sv
module spindle_mode_ctrl
  import spm_pkg::*;
#(
  parameter int ALIGN1_CYC = 64,
  parameter int ALIGN2_CYC = 192,
  parameter int BRAKE_DLY  = 1000,
  parameter int WD_LIMIT   = 65536
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       out_en,
  input  logic       run_brk,
  input  logic       seq_step,
  input  logic       align_ref,
  input  logic       zc_evt,
  output logic [2:0] phase,
  output logic       drv_en,
  output logic       brake
);
  logic ref_tick, ref_ok, seq_rise;
  logic clr, step1, step2;

  spm_ref_watch #(.WD_LIMIT(WD_LIMIT)) u_watch (
    .clk(clk), .rst_n(rst_n), .align_ref(align_ref),
    .ref_tick(ref_tick), .ref_ok(ref_ok)
  );

  spm_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .strobe(seq_step), .rise(seq_rise)
  );

  spm_mode_fsm #(
    .ALIGN1_CYC(ALIGN1_CYC), .ALIGN2_CYC(ALIGN2_CYC), .BRAKE_DLY(BRAKE_DLY)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .run_brk(run_brk), .out_en(out_en),
    .seq_step(seq_step), .seq_rise(seq_rise), .zc_evt(zc_evt),
    .ref_tick(ref_tick), .ref_ok(ref_ok),
    .clr(clr), .step1(step1), .step2(step2),
    .drv_en(drv_en), .brake(brake)
  );

  spm_phase_reg u_phase (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step1(step1), .step2(step2),
    .phase(phase)
  );

  // R1: run/brake low always turns the drivers off next clock
  a_r1_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run_brk |=> !drv_en);
  // R8: output-enable low always tristates next clock
  a_r8_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !drv_en);
  // R11: drivers only switch on while the reference is present
  a_r11_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> $past(ref_ok));
  // R10: never drive and brake together
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(brake && drv_en));

endmodule

// File: tb/sim_spindle_mode_ctrl.sv
module sim_spindle_mode_ctrl;
  localparam int A1 = 64;
  localparam int A2 = 192;
  localparam int BD = 100;
  localparam int WD = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic out_en = 1'b0, run_brk = 1'b0, seq_step = 1'b0, align_ref = 1'b0, zc_evt = 1'b0;
  logic [2:0] phase;
  logic drv_en, brake;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spindle_mode_ctrl #(.ALIGN1_CYC(A1), .ALIGN2_CYC(A2), .BRAKE_DLY(BD), .WD_LIMIT(WD)) u0 (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .run_brk(run_brk),
    .seq_step(seq_step), .align_ref(align_ref), .zc_evt(zc_evt),
    .phase(phase), .drv_en(drv_en), .brake(brake)
  );

  // stepping-mode vectors: {seq_step level, zc pulse, expected phase}
  localparam logic [4:0] EXT_VEC [13] = '{
    {1'b1, 1'b0, 3'd2}, {1'b1, 1'b0, 3'd2}, {1'b1, 1'b1, 3'd2}, {1'b0, 1'b0, 3'd2},
    {1'b1, 1'b0, 3'd3}, {1'b0, 1'b1, 3'd4}, {1'b0, 1'b1, 3'd5}, {1'b0, 1'b1, 3'd6},
    {1'b1, 1'b0, 3'd1}, {1'b0, 1'b0, 3'd1}, {1'b1, 1'b0, 3'd2}, {1'b0, 1'b0, 3'd2},
    {1'b1, 1'b1, 3'd3}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ref_pulse();
    align_ref = 1'b1; wait_clk(4);
    align_ref = 1'b0; wait_clk(4);
  endtask

  task automatic zc_pulse();
    zc_evt = 1'b1; wait_clk(1);
    zc_evt = 1'b0;
  endtask

  function automatic int nxt_ph(input int p);
    return (p % 6) + 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(1);
    chk(phase, 1, "R1 reset phase");
    chk(drv_en, 0, "R1 reset drv_en");
    chk(brake, 0, "R1 reset brake");

    // R11: no reference yet, start must be refused
    out_en = 1'b1; run_brk = 1'b1;
    wait_clk(20);
    chk(drv_en, 0, "R11 start blocked without reference");
    chk(phase, 1, "R11 phase idle without reference");
    run_brk = 1'b0;
    repeat (3) ref_pulse();
    wait_clk(4);

    // R2..R4 alignment
    run_brk = 1'b1;
    wait_clk(2);
    chk(phase, 2, "R2 first alignment phase");
    chk(drv_en, 1, "R2 drivers on");
    repeat (10) ref_pulse();
    seq_step = 1'b1; wait_clk(2);
    chk(phase, 2, "R5 strobe ignored in alignment");
    seq_step = 1'b0; wait_clk(1);
    repeat (A1 - 11) ref_pulse();
    chk(phase, 2, "R2 still aligned before last edge");
    ref_pulse();
    chk(phase, 4, "R3 second alignment phase");
    repeat (A2 - 1) ref_pulse();
    chk(phase, 4, "R3 still aligned before last edge");
    ref_pulse();
    chk(phase, 6, "R4 go phase");
    chk(drv_en, 1, "R4 drivers on in run");

    // R4/R12 run with zero crossings
    p = 6;
    for (int i = 0; i < 7; i++) begin
      zc_pulse();
      p = nxt_ph(p);
      chk(phase, p, "R4 R12 crossing advances phase");
    end

    // R8 tristate, R9 resync
    out_en = 1'b0; wait_clk(1);
    chk(drv_en, 0, "R8 tristate on out_en low");
    zc_pulse();
    chk(phase, p, "R8 crossing ignored while tristated");
    out_en = 1'b1; wait_clk(2);
    chk(drv_en, 0, "R9 drivers off until crossing");
    zc_pulse();
    p = nxt_ph(p);
    chk(phase, p, "R9 resync locks with one step");
    chk(drv_en, 1, "R9 drivers on after resync");

    // R10 coast then brake
    run_brk = 1'b0; wait_clk(1);
    chk(drv_en, 0, "R1 run_brk low drivers off");
    chk(phase, 1, "R1 run_brk low phase 1");
    chk(brake, 0, "R10 coasting not braking");
    wait_clk(BD - 4);
    chk(brake, 0, "R10 still coasting before delay end");
    wait_clk(6);
    chk(brake, 1, "R10 brake after delay");
    chk(drv_en, 0, "R10 drivers off in brake");

    // R11 reference lost while braking
    wait_clk(WD + 100);
    run_brk = 1'b1; wait_clk(3);
    chk(drv_en, 0, "R11 restart blocked after reference loss");
    chk(brake, 1, "R11 stays braked");
    ref_pulse();
    chk(phase, 2, "R11 start once reference returns");
    run_brk = 1'b0; wait_clk(2);

    // R6/R7 external stepping
    rst_n = 1'b0; wait_clk(2);
    rst_n = 1'b1; out_en = 1'b0; run_brk = 1'b0;
    seq_step = 1'b1; wait_clk(2);
    seq_step = 1'b0; wait_clk(1);
    repeat (3) ref_pulse();
    out_en = 1'b1; run_brk = 1'b1; wait_clk(2);
    chk(phase, 1, "R6 stepping start phase");
    chk(drv_en, 1, "R6 stepping start drivers on");
    for (int i = 0; i < 13; i++) begin
      seq_step = EXT_VEC[i][4];
      zc_evt   = EXT_VEC[i][3];
      wait_clk(1);
      zc_evt   = 1'b0;
      chk(phase, int'(EXT_VEC[i][2:0]), "R6 R7 R12 stepping vector");
    end
    seq_step = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule